// File: doc/BRIEF.md
# APM Command Port SMI Dispatcher

This block sits behind the power-management control port of a chipset's legacy logic. Firmware or the operating system writes one command byte to that port. Two reserved codes switch the platform between legacy mode and ACPI mode by setting or clearing a system-control-interrupt enable flag. Every other code is a request for firmware service. Such a request raises a one-cycle system-management interrupt pulse, but only when a gate bit in a small local configuration window allows it.

The configuration window is four bytes wide. A byte-write port with an 8-bit offset updates it, and a combinational read port lets the surrounding register logic return its contents. A board strap tells the block whether a management-mode handler exists. When it does not, reset opens the SMI gate by default. A second tie-off input reports whether the interrupt line is wired at all. When it is low, no request ever leaves the block.

Top module: `apm_smi_dispatch`

## Requirements
- R1: A control-port write of 0xF1 sets `sci_en_o` from the next clock onward and produces no pulse on `smi_req_o`.
- R2: A control-port write of 0xF0 clears `sci_en_o` from the next clock onward and produces no pulse on `smi_req_o`.
- R3: A control-port write of any other value leaves `sci_en_o` unchanged. If bit 1 of the window byte at offset 0x5B is set and `smi_wired_i` is high, `smi_req_o` is high in the cycle after the write.
- R4: When bit 1 of the byte at 0x5B is clear, no control-port write produces an SMI pulse, whatever the other bits of that byte hold.
- R5: While `smi_wired_i` is low, `smi_req_o` stays low for every command.
- R6: A synchronous reset (`rst_n` low at a clock edge) clears `sci_en_o` and `smi_req_o`. With `smm_present_i` high, it clears all four window bytes at 0x58 to 0x5B.
- R7: With `smm_present_i` low, reset loads 0x02 into the byte at 0x5B and clears the other three bytes.
- R8: Each qualifying write gives exactly one high cycle on `smi_req_o`. Writes on consecutive cycles give consecutive high cycles, and the output falls in the cycle after the last one.
- R9: A configuration write at an offset from 0x58 to 0x5B updates that byte, readable from the next cycle. Writes at any other offset change nothing in the window, and reads at other offsets return 0x00.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_present_i | input | 1 | Strap: high when a management-mode handler exists |
| smi_wired_i | input | 1 | Tie-off: high when the SMI line is connected |
| apm_wr_i | input | 1 | Control-port byte write strobe |
| apm_data_i | input | 8 | Control-port command byte |
| cfg_wr_i | input | 1 | Window byte write strobe |
| cfg_waddr_i | input | 8 | Window write offset |
| cfg_wdata_i | input | 8 | Window write data |
| cfg_raddr_i | input | 8 | Window read offset |
| cfg_rdata_o | output | 8 | Window read data (combinational) |
| sci_en_o | output | 1 | System-control-interrupt enable flag |
| smi_req_o | output | 1 | One-cycle SMI request pulse |

## Verification
Both the flag and the SMI pulse come from a single register stage, so each is due in the cycle right after the clock edge that samples the write. A window byte written at one edge can be read from the following cycle. The bench drives every stimulus on the falling edge and samples one falling edge later. It reads the pulse in that half-cycle and confirms it is gone one full cycle later. Reset defaults are read back through the window read port once the reset edge has passed.

// File: rtl/apm_smi_pkg.sv
// Package: shared constants for the APM command dispatcher.
// Assumes 8-bit command and window bytes.
package apm_smi_pkg;
    localparam int unsigned BYTE_W       = 8;
    localparam logic [7:0]  CMD_ACPI_ON  = 8'hF1;
    localparam logic [7:0]  CMD_ACPI_OFF = 8'hF0;
    localparam logic [7:0]  GATE_RST_VAL = 8'h02;

    // Classification of one control-port write.
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ON   = 2'd1,
        CMD_OFF  = 2'd2,
        CMD_SVC  = 2'd3
    } apm_cmd_e;
endpackage

// File: rtl/apm_cfg_window.sv
// Module: small byte-addressed configuration window.
// Holds CFG_BYTES bytes starting at offset CFG_BASE. Writes outside the
// window are dropped and reads outside it return zero. One byte (GATE_IDX)
// resets to GATE_RST when no management-mode handler is strapped present.
// Assumes writes are one byte wide and the window lies inside the offset range.
module apm_cfg_window #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CFG_BASE  = 'h58,
    parameter int unsigned CFG_BYTES = 4,
    parameter int unsigned GATE_IDX  = 3,
    parameter int unsigned GATE_BIT  = 1,
    parameter logic [DATA_W-1:0] GATE_RST = 'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smm_present_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              gate_o
);
    localparam int unsigned IDX_W = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(CFG_BASE + CFG_BYTES - 1);

    logic [DATA_W-1:0] bytes_q [CFG_BYTES];
    logic              w_hit, r_hit;
    logic [ADDR_W-1:0] w_off, r_off;
    logic [IDX_W-1:0]  w_idx, r_idx;

    // Decode write and read offsets against the window.
    always_comb begin
        w_hit = (waddr_i >= BASE_A) && (waddr_i <= LAST_A);
        r_hit = (raddr_i >= BASE_A) && (raddr_i <= LAST_A);
        w_off = waddr_i - BASE_A;
        r_off = raddr_i - BASE_A;
        w_idx = w_off[IDX_W-1:0];
        r_idx = r_off[IDX_W-1:0];
    end

    for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
        localparam bit IS_GATE = (i == GATE_IDX);
        // Per-byte storage with strap-dependent reset value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[i] <= (IS_GATE && !smm_present_i) ? GATE_RST : '0;
            end else if (wr_i && w_hit && (w_idx == IDX_W'(i))) begin
                bytes_q[i] <= wdata_i;
            end
        end
    end

    // Read mux; zero outside the window.
    always_comb begin
        rdata_o = r_hit ? bytes_q[r_idx] : '0;
    end

    assign gate_o = bytes_q[GATE_IDX][GATE_BIT];
endmodule

// File: rtl/apm_cmd_decode.sv
// Module: classifies a control-port write into mode switch or service request.
// Purely combinational; assumes the strobe is valid for one cycle per byte.
module apm_cmd_decode
    import apm_smi_pkg::*;
#(
    parameter logic [7:0] CODE_ON  = CMD_ACPI_ON,
    parameter logic [7:0] CODE_OFF = CMD_ACPI_OFF
) (
    input  logic       wr_i,
    input  logic [7:0] data_i,
    output apm_cmd_e   cmd_o
);
    // Map the written byte to a command class.
    always_comb begin
        if (!wr_i)                 cmd_o = CMD_NONE;
        else if (data_i == CODE_ON)  cmd_o = CMD_ON;
        else if (data_i == CODE_OFF) cmd_o = CMD_OFF;
        else                         cmd_o = CMD_SVC;
    end
endmodule

// File: rtl/apm_mode_ctl.sv
// Module: holds the SCI enable flag and issues the registered SMI pulse.
// A service command pulses the request for one cycle when gated open and
// the line is wired. Assumes the decoder presents at most one command a cycle.
module apm_mode_ctl
    import apm_smi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  apm_cmd_e cmd_i,
    input  logic     gate_i,
    input  logic     wired_i,
    output logic     sci_en_o,
    output logic     smi_req_o
);
    // Mode flag update on the two switch codes.
    always_ff @(posedge clk) begin
        if (!rst_n)               sci_en_o <= 1'b0;
        else if (cmd_i == CMD_ON)  sci_en_o <= 1'b1;
        else if (cmd_i == CMD_OFF) sci_en_o <= 1'b0;
    end

    // One-cycle SMI request for each qualifying service command.
    always_ff @(posedge clk) begin
        if (!rst_n) smi_req_o <= 1'b0;
        else        smi_req_o <= (cmd_i == CMD_SVC) && gate_i && wired_i;
    end
endmodule

// File: rtl/apm_smi_dispatch.sv
// Module: top of the APM command port dispatcher.
// Ties the command decoder, the mode/SMI controller and the configuration
// window together. Assumes a single clock and synchronous active-low reset.
module apm_smi_dispatch
    import apm_smi_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CFG_BASE  = 'h58,
    parameter int unsigned CFG_BYTES = 4,
    parameter int unsigned GATE_IDX  = 3,
    parameter int unsigned GATE_BIT  = 1,
    parameter logic [7:0]  CODE_ON   = CMD_ACPI_ON,
    parameter logic [7:0]  CODE_OFF  = CMD_ACPI_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smm_present_i,
    input  logic              smi_wired_i,
    input  logic              apm_wr_i,
    input  logic [7:0]        apm_data_i,
    input  logic              cfg_wr_i,
    input  logic [ADDR_W-1:0] cfg_waddr_i,
    input  logic [7:0]        cfg_wdata_i,
    input  logic [ADDR_W-1:0] cfg_raddr_i,
    output logic [7:0]        cfg_rdata_o,
    output logic              sci_en_o,
    output logic              smi_req_o
);
    apm_cmd_e cmd;
    logic     smi_gate;

    apm_cmd_decode #(
        .CODE_ON (CODE_ON),
        .CODE_OFF(CODE_OFF)
    ) u_dec (
        .wr_i  (apm_wr_i),
        .data_i(apm_data_i),
        .cmd_o (cmd)
    );

    apm_cfg_window #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (BYTE_W),
        .CFG_BASE (CFG_BASE),
        .CFG_BYTES(CFG_BYTES),
        .GATE_IDX (GATE_IDX),
        .GATE_BIT (GATE_BIT),
        .GATE_RST (GATE_RST_VAL)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .smm_present_i(smm_present_i),
        .wr_i         (cfg_wr_i),
        .waddr_i      (cfg_waddr_i),
        .wdata_i      (cfg_wdata_i),
        .raddr_i      (cfg_raddr_i),
        .rdata_o      (cfg_rdata_o),
        .gate_o       (smi_gate)
    );

    apm_mode_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .gate_i   (smi_gate),
        .wired_i  (smi_wired_i),
        .sci_en_o (sci_en_o),
        .smi_req_o(smi_req_o)
    );
endmodule

// File: rtl/apm_smi_dispatch_chk.sv
// Module: protocol checker for apm_smi_dispatch, attached by bind.
// Relates control-port writes to the flag and pulse one cycle later.
module apm_smi_dispatch_chk #(
    parameter logic [7:0] CODE_ON  = 8'hF1,
    parameter logic [7:0] CODE_OFF = 8'hF0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       apm_wr_i,
    input logic [7:0] apm_data_i,
    input logic       smi_wired_i,
    input logic       gate_i,
    input logic       sci_en_o,
    input logic       smi_req_o
);
    logic is_on, is_off, is_svc;
    assign is_on  = apm_wr_i && (apm_data_i == CODE_ON);
    assign is_off = apm_wr_i && (apm_data_i == CODE_OFF);
    assign is_svc = apm_wr_i && !is_on && !is_off;

    AST_ON_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) is_on |=> sci_en_o); // R1
    AST_ON_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n) is_on |=> !smi_req_o); // R1
    AST_OFF_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) is_off |=> !sci_en_o); // R2
    AST_OFF_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n) is_off |=> !smi_req_o); // R2
    AST_SVC_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (is_svc || !apm_wr_i) |=> $stable(sci_en_o)); // R3
    AST_SVC_FIRES: assert property (@(posedge clk) disable iff (!rst_n) (is_svc && gate_i && smi_wired_i) |=> smi_req_o); // R3
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) !gate_i |=> !smi_req_o); // R4
    AST_UNWIRED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !smi_wired_i |=> !smi_req_o); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!sci_en_o && !smi_req_o)); // R6
    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) smi_req_o |-> $past(is_svc)); // R8
endmodule

bind apm_smi_dispatch apm_smi_dispatch_chk #(
    .CODE_ON (CODE_ON),
    .CODE_OFF(CODE_OFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .apm_wr_i   (apm_wr_i),
    .apm_data_i (apm_data_i),
    .smi_wired_i(smi_wired_i),
    .gate_i     (smi_gate),
    .sci_en_o   (sci_en_o),
    .smi_req_o  (smi_req_o)
);

// File: tb/tb_apm_smi_dispatch.sv
module tb_apm_smi_dispatch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smm_present_i = 1'b1;
    logic       smi_wired_i = 1'b1;
    logic       apm_wr_i = 1'b0;
    logic [7:0] apm_data_i = 8'h00;
    logic       cfg_wr_i = 1'b0;
    logic [7:0] cfg_waddr_i = 8'h00;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic [7:0] cfg_raddr_i = 8'h00;
    logic [7:0] cfg_rdata_o;
    logic       sci_en_o;
    logic       smi_req_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    apm_smi_dispatch dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .smm_present_i(smm_present_i),
        .smi_wired_i  (smi_wired_i),
        .apm_wr_i     (apm_wr_i),
        .apm_data_i   (apm_data_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_waddr_i  (cfg_waddr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .cfg_raddr_i  (cfg_raddr_i),
        .cfg_rdata_o  (cfg_rdata_o),
        .sci_en_o     (sci_en_o),
        .smi_req_o    (smi_req_o)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Assumes the caller sits at a falling edge.
    task automatic do_reset(input logic strap);
        smm_present_i = strap;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One control-port write; returns one half-cycle after the sampling edge.
    task automatic apm_write(input logic [7:0] d);
        apm_wr_i = 1'b1;
        apm_data_i = d;
        @(negedge clk);
        apm_wr_i = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_wr_i = 1'b1;
        cfg_waddr_i = a;
        cfg_wdata_i = d;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        cfg_raddr_i = a;
        #1;
        d = cfg_rdata_o;
    endtask

    task automatic t_reset_defaults();
        logic [7:0] v;
        apm_write(8'hF1);
        cfg_write(8'h59, 8'h77);
        do_reset(1'b1);
        check("R6", "sci after reset", {7'b0, sci_en_o}, 8'h00);
        check("R6", "smi after reset", {7'b0, smi_req_o}, 8'h00);
        for (int a = 'h58; a <= 'h5B; a++) begin
            cfg_read(8'(a), v);
            check("R6", "window byte", v, 8'h00);
        end
        @(negedge clk);
        do_reset(1'b0);
        cfg_read(8'h5B, v);
        check("R7", "gate byte default", v, 8'h02);
        cfg_read(8'h58, v);
        check("R7", "byte 0x58 default", v, 8'h00);
    endtask

    task automatic t_acpi_on_off();
        apm_write(8'hF1);
        check("R1", "sci after F1", {7'b0, sci_en_o}, 8'h01);
        check("R1", "no smi on F1", {7'b0, smi_req_o}, 8'h00);
        @(negedge clk);
        apm_write(8'hF0);
        check("R2", "sci after F0", {7'b0, sci_en_o}, 8'h00);
        check("R2", "no smi on F0", {7'b0, smi_req_o}, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_service_pulse();
        apm_write(8'hF1);
        apm_write(8'h52);
        check("R3", "smi after service code", {7'b0, smi_req_o}, 8'h01);
        check("R3", "sci kept high", {7'b0, sci_en_o}, 8'h01);
        @(negedge clk);
        check("R8", "pulse ends", {7'b0, smi_req_o}, 8'h00);
        apm_write(8'hF0);
        apm_write(8'h00);
        check("R3", "sci kept low", {7'b0, sci_en_o}, 8'h00);
        check("R3", "smi on 0x00", {7'b0, smi_req_o}, 8'h01);
        @(negedge clk);
    endtask

    task automatic t_back_to_back();
        apm_write(8'h10);
        check("R8", "first pulse", {7'b0, smi_req_o}, 8'h01);
        apm_write(8'h20);
        check("R8", "second pulse", {7'b0, smi_req_o}, 8'h01);
        @(negedge clk);
        check("R8", "low after burst", {7'b0, smi_req_o}, 8'h00);
    endtask

    task automatic t_gate_closed();
        logic [7:0] v;
        cfg_write(8'h5B, 8'h00);
        cfg_read(8'h5B, v);
        check("R9", "gate byte written", v, 8'h00);
        apm_write(8'h33);
        check("R4", "no smi gate clear", {7'b0, smi_req_o}, 8'h00);
        cfg_write(8'h5B, 8'hFD);
        apm_write(8'h34);
        check("R4", "no smi other bits set", {7'b0, smi_req_o}, 8'h00);
        cfg_write(8'h5B, 8'h02);
    endtask

    task automatic t_unwired();
        smi_wired_i = 1'b0;
        apm_write(8'h44);
        check("R5", "no smi when unwired", {7'b0, smi_req_o}, 8'h00);
        @(negedge clk);
        smi_wired_i = 1'b1;
    endtask

    task automatic t_window_range();
        logic [7:0] v;
        cfg_write(8'h58, 8'hA5);
        cfg_read(8'h58, v);
        check("R9", "byte 0x58 written", v, 8'hA5);
        cfg_write(8'h57, 8'hFF);
        cfg_write(8'h5C, 8'h00);
        cfg_read(8'h57, v);
        check("R9", "read below window", v, 8'h00);
        cfg_read(8'h5C, v);
        check("R9", "read above window", v, 8'h00);
        cfg_read(8'h5B, v);
        check("R9", "gate byte untouched", v, 8'h02);
        cfg_read(8'h58, v);
        check("R9", "byte 0x58 untouched", v, 8'hA5);
        apm_write(8'h11);
        check("R9", "gate still open", {7'b0, smi_req_o}, 8'h01);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        t_reset_defaults();
        t_acpi_on_off();
        t_service_pulse();
        t_back_to_back();
        t_gate_closed();
        t_unwired();
        t_window_range();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule